// File: doc/BRIEF.md
# Zero-Wait-State Synchronous SRAM Core

This block is a single-clock synchronous static memory that accepts a new read or write command on every clock edge, in any order, with no turnaround cycle between them. Address, chip selects, the read/write select and the advance control are registered on the rising edge. The write data and the per-lane write strobes for a write are captured one edge later. Read data comes out flow-through: it is looked up combinationally from the registered address. It is therefore valid in the cycle right after the edge that accepted the read.

A clock-enable input that is active low freezes the whole pipeline. A sleep input also freezes it and releases the data bus. An advance input carries a four-beat burst forward from the loaded start address and wraps within the aligned group of four words. The array is a parameterised register file, 256 words of two 9-bit lanes by default. A host uses it as a fast scratch memory. It drives a command each cycle, presents the write data one cycle after the write command, and samples the read data one cycle after the read command.

Top module: `nowait_sram`

## Requirements
- R1: After reset no operation is pending, so `dq_oe` is 0 and the first edge with a data strobe writes nothing.
- R2: On an accepted edge (`cke_n`=0, `sleep`=0, `adv`=0, device selected), `we_n`=1 loads a read and `we_n`=0 loads a write at `addr`. After a read edge, `dq_out` shows the stored word at that address in the same following cycle, with no extra register.
- R3: Write data `wdata` and strobes `bw_n` are taken on the accepted edge one cycle after the write command. Lane i covers bits [9*i+8 : 9*i] and is written only when `bw_n[i]` is 0.
- R4: A write whose data edge has `bw_n` all ones is a write abort and leaves every stored word unchanged.
- R5: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. On any other combination the edge loads no operation: memory is unchanged and `dq_oe` is 0.
- R6: With `cke_n`=1 the edge is ignored. The registered command, burst position and output stay as they were, and a pending write does not capture data.
- R7: With `adv`=1 on an accepted edge, the previous operation continues at the next burst address. The upper address bits are held and the low two bits become (start + k) mod 4 for beat k. Chip selects and `we_n` are ignored on such an edge. After a deselect, `adv`=1 keeps the device idle.
- R8: Reads and writes follow each other on consecutive edges with no gap. A read of an address on the edge right after a write command to it returns the newly written data.
- R9: `dq_oe` is 1 only while `oe_n`=0, `sleep`=0 and the last loaded operation is a read. A read with `oe_n`=1 is a dummy read that drives nothing.
- R10: While `sleep`=1, edges are ignored as in R6, memory keeps its contents and `dq_oe` is 0. A write pending before sleep completes on the first accepted edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the command pipeline |
| cke_n | input | 1 | Active-low clock enable; high ignores the edge |
| sleep | input | 1 | High freezes the pipeline and releases the bus |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| adv | input | 1 | High continues the burst, low loads a new command |
| we_n | input | 1 | High read, low write |
| addr | input | AW (8) | Word address |
| bw_n | input | LANES (2) | Active-low lane write strobes, one cycle after the write command |
| wdata | input | LANES*LANE_W (18) | Write data, one cycle after the write command |
| oe_n | input | 1 | Active-low output enable |
| dq_out | output | LANES*LANE_W (18) | Flow-through read data |
| dq_oe | output | 1 | 1 when the data bus is driven, 0 means high impedance |

## Verification
Every word of the array is written with back-to-back write commands and then read back with back-to-back reads. A data-capture slip of one cycle would put every value one address off. Single-lane strobes and the all-ones abort are checked against a bench model, which catches a design that ignores a strobe or writes on an abort. Bursts from unaligned starts are checked for wrap-around, and a carry into the upper address bits would show up there. The same-address write-then-read pair, all seven deselecting select combinations, frozen edges under `cke_n` and `sleep`, and a pending write that spans a sleep period target a design that drops or misplaces the delayed write data.

// File: rtl/nws_pkg.sv
package nws_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    localparam int BURST_BITS = 2;
endpackage

// File: rtl/nws_cmd.sv
module nws_cmd
    import nws_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          sel,
    input  logic          adv,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output op_e           op_q,
    output logic [AW-1:0] eff_addr,
    output logic          wr_fire
);
    localparam int BB = BURST_BITS;

    typedef struct packed {
        op_e           op;
        logic [AW-1:0] base;
        logic [BB-1:0] cnt;
    } cmd_st_t;

    cmd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (adv) begin
                if (st_q.op != OP_IDLE) begin
                    st_d.cnt = st_q.cnt + BB'(1);
                end
            end else if (!sel) begin
                st_d.op = OP_IDLE;
            end else begin
                st_d.op   = we_n ? OP_READ : OP_WRITE;
                st_d.base = addr;
                st_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{op: OP_IDLE, base: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign op_q     = st_q.op;
    assign eff_addr = {st_q.base[AW-1:BB], st_q.base[BB-1:0] + st_q.cnt};
    assign wr_fire  = step && (st_q.op == OP_WRITE);

    // R6 R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(st_q));

    // R5
    desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !adv && !sel) |=> (op_q == OP_IDLE));

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !adv && sel) |=> (eff_addr == $past(addr)));

    // R7
    burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && adv && op_q != OP_IDLE) |=>
            (op_q == $past(op_q)) &&
            (eff_addr[AW-1:BB] == $past(eff_addr[AW-1:BB])) &&
            (eff_addr[BB-1:0] == BB'($past(eff_addr[BB-1:0]) + BB'(1))));
endmodule

// File: rtl/nws_array.sv
module nws_array #(
    parameter int AW     = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_fire,
    input  logic [AW-1:0]           waddr,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic              lane_we;

        assign lane_we = wr_fire && !bw_n[g];

        always_ff @(posedge clk) begin
            if (lane_we) begin
                lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[waddr];

        // R3
        lane_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_fire && !bw_n[g]) |=>
                (lane_mem[$past(waddr)] == $past(wdata[g*LANE_W +: LANE_W])));
    end
endmodule

// File: rtl/nowait_sram.sv
module nowait_sram
    import nws_pkg::*;
#(
    parameter int AW     = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    sleep,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    adv,
    input  logic                    we_n,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);
    logic          step;
    logic          sel;
    op_e           op_q;
    logic [AW-1:0] eff_addr;
    logic          wr_fire;

    assign step = !cke_n && !sleep;
    assign sel  = !ce1_n && ce2 && !ce3_n;

    nws_cmd #(.AW(AW)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .sel      (sel),
        .adv      (adv),
        .we_n     (we_n),
        .addr     (addr),
        .op_q     (op_q),
        .eff_addr (eff_addr),
        .wr_fire  (wr_fire)
    );

    nws_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .waddr   (eff_addr),
        .bw_n    (bw_n),
        .wdata   (wdata),
        .rdata   (dq_out)
    );

    assign dq_oe = !oe_n && !sleep && (op_q == OP_READ);

    // R9 R10
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || sleep) |-> !dq_oe);

    // R5
    desel_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !adv && !sel) |=> !dq_oe);
endmodule

// File: tb/nowait_sram_tb.sv
module nowait_sram_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] SEL = 3'b010;
    localparam logic [2:0] OFF = 3'b110;

    logic        clk = 1'b0;
    logic        rst_n, cke_n, sleep, ce1_n, ce2, ce3_n, adv, we_n, oe_n;
    logic [7:0]  addr;
    logic [1:0]  bw_n;
    logic [17:0] wdata;
    logic [17:0] dq_out;
    logic        dq_oe;

    logic [17:0] exp_mem [256];
    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nowait_sram u_dut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sleep(sleep),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv(adv), .we_n(we_n),
        .addr(addr), .bw_n(bw_n), .wdata(wdata), .oe_n(oe_n),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [17:0] pat(input int a);
        return 18'((a * 37 + 11) ^ (a << 9));
    endfunction

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic a_adv, input logic [2:0] ce, input logic a_we_n,
                       input logic [7:0] a, input logic [17:0] d, input logic [1:0] bw,
                       input logic ck_n, input logic slp);
        adv = a_adv; {ce1_n, ce2, ce3_n} = ce; we_n = a_we_n;
        addr = a; wdata = d; bw_n = bw; cke_n = ck_n; sleep = slp;
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [7:0] a);
        cyc(1'b0, SEL, 1'b1, a, 18'h0, 2'b11, 1'b0, 1'b0);
    endtask

    // write command at a, carrying data/strobes for the previous write
    task automatic wr(input logic [7:0] a, input logic [17:0] d, input logic [1:0] bw);
        cyc(1'b0, SEL, 1'b0, a, d, bw, 1'b0, 1'b0);
    endtask

    task automatic idle(input logic [17:0] d, input logic [1:0] bw);
        cyc(1'b0, OFF, 1'b1, 8'h0, d, bw, 1'b0, 1'b0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; cke_n = 1'b0; sleep = 1'b0; {ce1_n, ce2, ce3_n} = OFF;
        adv = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = '0; bw_n = 2'b11; wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk("R1 reset dq_oe", 18'(dq_oe), 18'd0);

        // R2 R8: full sweep of back-to-back writes, then back-to-back reads
        for (int a = 0; a < 256; a++) begin
            wr(8'(a), (a == 0) ? 18'h0 : pat(a - 1), 2'b00);
            exp_mem[a] = pat(a);
        end
        idle(pat(255), 2'b00);
        for (int a = 0; a < 256; a++) begin
            rd(8'(a));
            chk("R2 sweep read", dq_out, exp_mem[a]);
        end
        chk("R9 read drives bus", 18'(dq_oe), 18'd1);

        // R9 dummy read with output enable off
        oe_n = 1'b1;
        rd(8'd3);
        chk("R9 dummy read bus off", 18'(dq_oe), 18'd0);
        oe_n = 1'b0;

        // R3 lane strobes
        wr(8'd5, 18'h0, 2'b11);
        idle(18'h3ffff, 2'b10);
        exp_mem[5][8:0] = 9'h1ff;
        rd(8'd5);
        chk("R3 lane0 only", dq_out, exp_mem[5]);
        wr(8'd5, 18'h0, 2'b11);
        idle(18'h0, 2'b01);
        exp_mem[5][17:9] = 9'h0;
        rd(8'd5);
        chk("R3 lane1 only", dq_out, exp_mem[5]);

        // R4 write abort
        wr(8'd6, 18'h0, 2'b11);
        idle(18'h0, 2'b11);
        rd(8'd6);
        chk("R4 abort keeps word", dq_out, exp_mem[6]);

        // R8 alternating write then read of the same address, no gaps
        for (int a = 16; a < 32; a++) begin
            wr(8'(a), 18'h0, 2'b11);
            if (a == 16) chk("R9 write cmd bus off", 18'(dq_oe), 18'd0);
            exp_mem[a] = pat(a + 1000);
            cyc(1'b0, SEL, 1'b1, 8'(a), exp_mem[a], 2'b00, 1'b0, 1'b0);
            chk("R8 read after write", dq_out, exp_mem[a]);
        end

        // R5 every deselecting chip-select combination
        for (int c = 0; c < 8; c++) begin
            if (c != 2) begin
                cyc(1'b0, 3'(c), 1'(c & 1), 8'd9, 18'h0, 2'b11, 1'b0, 1'b0);
                chk("R5 deselect bus off", 18'(dq_oe), 18'd0);
                idle(18'h2aaaa, 2'b00);
            end
        end
        rd(8'd9);
        chk("R5 deselect keeps memory", dq_out, exp_mem[9]);

        // R6 clock enable freeze
        rd(8'd10);
        cyc(1'b0, SEL, 1'b1, 8'd11, 18'h0, 2'b11, 1'b1, 1'b0);
        chk("R6 frozen output", dq_out, exp_mem[10]);
        chk("R6 frozen bus enable", 18'(dq_oe), 18'd1);
        wr(8'd12, 18'h0, 2'b11);
        cyc(1'b0, SEL, 1'b1, 8'd0, 18'h15555, 2'b00, 1'b1, 1'b0);
        idle(18'h0aaaa, 2'b00);
        exp_mem[12] = 18'h0aaaa;
        rd(8'd12);
        chk("R6 pending write after freeze", dq_out, exp_mem[12]);

        // R7 read burst from unaligned start, wrapping in group of four
        rd(8'h41);
        chk("R7 burst beat0", dq_out, exp_mem[8'h41]);
        cyc(1'b1, OFF, 1'b0, 8'h00, 18'h0, 2'b11, 1'b0, 1'b0);
        chk("R7 burst beat1", dq_out, exp_mem[8'h42]);
        cyc(1'b1, OFF, 1'b0, 8'h00, 18'h0, 2'b11, 1'b0, 1'b0);
        chk("R7 burst beat2", dq_out, exp_mem[8'h43]);
        cyc(1'b1, OFF, 1'b0, 8'h00, 18'h0, 2'b11, 1'b0, 1'b0);
        chk("R7 burst wrap", dq_out, exp_mem[8'h40]);
        cyc(1'b1, SEL, 1'b1, 8'h00, 18'h0, 2'b11, 1'b0, 1'b0);
        chk("R7 burst beat4", dq_out, exp_mem[8'h41]);

        // R7 write burst
        wr(8'h52, 18'h0, 2'b11);
        cyc(1'b1, SEL, 1'b1, 8'h0, 18'h10001, 2'b00, 1'b0, 1'b0);
        cyc(1'b1, SEL, 1'b1, 8'h0, 18'h10002, 2'b00, 1'b0, 1'b0);
        cyc(1'b1, SEL, 1'b1, 8'h0, 18'h10003, 2'b00, 1'b0, 1'b0);
        idle(18'h10004, 2'b00);
        exp_mem[8'h52] = 18'h10001; exp_mem[8'h53] = 18'h10002;
        exp_mem[8'h50] = 18'h10003; exp_mem[8'h51] = 18'h10004;
        for (int a = 8'h50; a < 8'h54; a++) begin
            rd(8'(a));
            chk("R7 write burst word", dq_out, exp_mem[a]);
        end
        rd(8'h54);
        chk("R7 no write past group", dq_out, exp_mem[8'h54]);

        // R7 advance after deselect stays idle
        idle(18'h0, 2'b11);
        cyc(1'b1, SEL, 1'b1, 8'h41, 18'h0, 2'b11, 1'b0, 1'b0);
        chk("R7 advance while idle", 18'(dq_oe), 18'd0);

        // R10 sleep
        rd(8'd10);
        cyc(1'b0, SEL, 1'b0, 8'd10, 18'h00001, 2'b00, 1'b0, 1'b1);
        chk("R10 sleep bus off", 18'(dq_oe), 18'd0);
        rd(8'd10);
        chk("R10 sleep keeps memory", dq_out, exp_mem[10]);
        wr(8'd13, 18'h0, 2'b11);
        cyc(1'b0, SEL, 1'b1, 8'd0, 18'h3f0f0, 2'b00, 1'b0, 1'b1);
        idle(18'h12345, 2'b00);
        exp_mem[13] = 18'h12345;
        rd(8'd13);
        chk("R10 pending write after sleep", dq_out, exp_mem[13]);

        summary();
        $finish;
    end
endmodule